// File: doc/BRIEF.md
# Power-Mode Clock Divider with Bus Clock Stage

This block produces a pair of non-overlapping system clock phases from a fast reference clock. The division ratio is a power of two, taken from one of two programmable fields. A two-bit power-mode input chooses the field: one field serves the two high-frequency modes (normal and doze), and the other serves the two low-frequency modes. The two fields are encoded differently. The high field gives the exponent directly. The low field gives the exponent minus one, so the low-frequency modes always divide by at least two. A second stage derives a slower pair of bus clock phases from the system phases. It either passes them through or divides them by two.

All outputs are registered waveforms on the fast clock `clk_i`. The undivided system clock lasts two `clk_i` cycles. When the factor N grows, the period becomes 2N cycles. The first phase keeps its one-cycle active width and its inactive part stretches. The result is deliberately not 50% duty. A new mode, a new divide field or a new bus field is picked up only at the boundary of a complete period, so no output ever shows a shortened pulse. The divide fields come from registers that hard reset clears to zero, which gives the undivided rate after reset.

Top module: `clkdiv_pwr_top`

## Requirements
- R1: While `hard_rst_i` is high all four outputs are low. In the cycle after the first clock edge following release, `sys_ph1_o` is high. With all fields at zero (their reset value) the system period is 2 cycles and the bus outputs equal the system outputs.
- R2: For a factor N the system period is 2N cycles. `sys_ph1_o` is high for exactly one cycle per period and low for 2N-1. `sys_ph2_o` is high for exactly one cycle, N cycles after `sys_ph1_o` rises. The two phases are never high together.
- R3: When `pwr_mode_i[1]` is 0 (high-frequency modes), N = 2^`div_hi_i`, giving factors 1 to 128.
- R4: When `pwr_mode_i[1]` is 1 (low-frequency modes), N = 2^(`div_lo_i`+1). The factor saturates at 128, so `div_lo_i` = 6 and `div_lo_i` = 7 both give 128.
- R5: `pwr_mode_i[0]` (doze) has no effect on the output timing. The divide field of the mode that is not selected has no effect.
- R6: A change of `pwr_mode_i`, `div_hi_i` or `div_lo_i` in the middle of a period leaves that period at its old length. The new factor applies from the next `sys_ph1_o` rise.
- R7: When `bus_div_i` is 0, `bus_ph1_o` and `bus_ph2_o` equal `sys_ph1_o` and `sys_ph2_o` cycle for cycle.
- R8: When `bus_div_i` is 1, the bus period is 4N cycles. `bus_ph1_o` is high together with `sys_ph1_o` on alternate system periods. `bus_ph2_o` is high together with `sys_ph2_o` in the other periods, 3N cycles after `bus_ph1_o` rises. Each bus rising edge coincides with a system rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| hard_rst_i | input | 1 | Synchronous active-high hard reset |
| pwr_mode_i | input | 2 | Bit 1: 0 high-frequency, 1 low-frequency; bit 0: doze |
| div_hi_i | input | 3 | Exponent used in the high-frequency modes |
| div_lo_i | input | 3 | Exponent minus one used in the low-frequency modes |
| bus_div_i | input | 1 | 0: bus equals system; 1: bus at half the system rate |
| sys_ph1_o | output | 1 | System clock, first phase |
| sys_ph2_o | output | 1 | System clock, second phase |
| bus_ph1_o | output | 1 | Bus clock, first phase |
| bus_ph2_o | output | 1 | Bus clock, second phase |

## Verification
The hardest case to reach from the ports is a divide field that changes partway through a long divided period. The rule that the old period must complete only shows if the change lands after the period has started. The stimulus first synchronises to a `sys_ph1_o` rise with a factor of 4, then changes the field two cycles later and counts the full period. A mode switch is also made during a divide-by-one period. This confirms that the low-frequency factor starts only at the following rise.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    // width of each divide field
    localparam int unsigned FIELD_W = 3;
    // largest exponent the divider supports (factor 2^LOG_MAX)
    localparam int unsigned LOG_MAX = 7;
    // counter holds 0 .. 2*2^LOG_MAX - 1, one spare bit for the last-value math
    localparam int unsigned CNT_W   = LOG_MAX + 2;
    localparam int unsigned SHIFT_W = $clog2(LOG_MAX + 1);

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [SHIFT_W-1:0] shift_t;
    typedef logic [CNT_W-1:0]   count_t;

    typedef enum logic [1:0] {
        PM_NORM_HI = 2'b00,
        PM_DOZE_HI = 2'b01,
        PM_NORM_LO = 2'b10,
        PM_DOZE_LO = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        count_t cnt;
        shift_t shift;
        logic   ph1;
        logic   ph2;
    } phase_state_t;

    typedef struct packed {
        logic div2;
        logic odd;
        logic ph1;
        logic ph2;
    } bus_state_t;

endpackage

// File: rtl/clkdiv_ratio_sel.sv
`timescale 1ns/1ps
module clkdiv_ratio_sel
    import clkdiv_pkg::*;
(
    input  logic [1:0] pwr_mode_i,
    input  field_t     hi_i,
    input  field_t     lo_i,
    output shift_t     shift_o
);

    localparam logic [FIELD_W:0] CAP_W = (FIELD_W + 1)'(LOG_MAX);

    logic [FIELD_W:0] lo_plus;
    logic [FIELD_W:0] hi_ext;

    always_comb begin
        lo_plus = {1'b0, lo_i} + {{FIELD_W{1'b0}}, 1'b1};
        hi_ext  = {1'b0, hi_i};
        if (pwr_mode_i[1]) begin
            // low-frequency modes: exponent is field + 1, capped
            shift_o = (lo_plus > CAP_W) ? shift_t'(CAP_W) : shift_t'(lo_plus);
        end else begin
            // high-frequency modes: exponent is the field itself
            shift_o = (hi_ext > CAP_W) ? shift_t'(CAP_W) : shift_t'(hi_ext);
        end
    end

endmodule

// File: rtl/clkdiv_phase_gen.sv
`timescale 1ns/1ps
module clkdiv_phase_gen
    import clkdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  shift_t shift_sel_i,
    output logic   ph1_o,
    output logic   ph2_o,
    output logic   ph1_nxt_o,
    output logic   ph2_nxt_o,
    output logic   wrap_o
);

    phase_state_t s_d, s_q;
    count_t       last_w;
    count_t       half_d;
    logic         wrap_w;

    always_comb begin
        s_d    = s_q;
        last_w = (count_t'(2) << s_q.shift) - count_t'(1);
        wrap_w = (s_q.cnt == last_w);
        if (wrap_w) begin
            // a new period starts: only here does a new factor get in
            s_d.cnt   = '0;
            s_d.shift = shift_sel_i;
        end else begin
            s_d.cnt   = s_q.cnt + count_t'(1);
        end
        half_d = count_t'(1) << s_d.shift;
        s_d.ph1 = (s_d.cnt == '0);
        s_d.ph2 = (s_d.cnt == half_d);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            // counter parked on the last count of a divide-by-one period
            s_q <= '{cnt: count_t'(1), shift: '0, ph1: 1'b0, ph2: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ph1_o     = s_q.ph1;
    assign ph2_o     = s_q.ph2;
    assign ph1_nxt_o = s_d.ph1;
    assign ph2_nxt_o = s_d.ph2;
    assign wrap_o    = wrap_w;

    // R2: phases never overlap
    a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (rst_i)
        !(s_q.ph1 && s_q.ph2));

    // R2: first phase is active for exactly one cycle
    a_r2_ph1_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        s_q.ph1 |=> !s_q.ph1);

    // R6: the applied factor only moves on a period start
    a_r6_change_at_boundary: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(s_q.shift) |-> s_q.ph1);

endmodule

// File: rtl/clkdiv_bus_stage.sv
`timescale 1ns/1ps
module clkdiv_bus_stage
    import clkdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bus_div_i,
    input  logic sys_wrap_i,
    input  logic sys_ph1_nxt_i,
    input  logic sys_ph2_nxt_i,
    input  logic sys_ph1_i,
    input  logic sys_ph2_i,
    output logic bus_ph1_o,
    output logic bus_ph2_o
);

    bus_state_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (sys_wrap_i) begin
            if (!b_q.div2 || b_q.odd) begin
                // bus period boundary: accept a new bus setting
                b_d.div2 = bus_div_i;
                b_d.odd  = 1'b0;
            end else begin
                b_d.odd  = 1'b1;
            end
        end
        b_d.ph1 = sys_ph1_nxt_i && !b_d.odd;
        b_d.ph2 = sys_ph2_nxt_i && (!b_d.div2 || b_d.odd);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            b_q <= '{div2: 1'b0, odd: 1'b0, ph1: 1'b0, ph2: 1'b0};
        end else begin
            b_q <= b_d;
        end
    end

    assign bus_ph1_o = b_q.ph1;
    assign bus_ph2_o = b_q.ph2;

    // R8: bus first phase only active with system first phase
    a_r8_bus_ph1_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
        b_q.ph1 |-> sys_ph1_i);

    // R8: bus second phase only active with system second phase
    a_r8_bus_ph2_aligned: assert property (@(posedge clk_i) disable iff (rst_i)
        b_q.ph2 |-> sys_ph2_i);

    // R7: undivided bus tracks the system phases exactly
    a_r7_bus_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        !b_q.div2 |-> (b_q.ph1 == sys_ph1_i && b_q.ph2 == sys_ph2_i));

endmodule

// File: rtl/clkdiv_pwr_top.sv
`timescale 1ns/1ps
module clkdiv_pwr_top
    import clkdiv_pkg::*;
(
    input  logic               clk_i,
    input  logic               hard_rst_i,
    input  logic [1:0]         pwr_mode_i,
    input  logic [FIELD_W-1:0] div_hi_i,
    input  logic [FIELD_W-1:0] div_lo_i,
    input  logic               bus_div_i,
    output logic               sys_ph1_o,
    output logic               sys_ph2_o,
    output logic               bus_ph1_o,
    output logic               bus_ph2_o
);

    shift_t shift_sel;
    logic   ph1_nxt;
    logic   ph2_nxt;
    logic   sys_wrap;

    clkdiv_ratio_sel ratio_i (
        .pwr_mode_i (pwr_mode_i),
        .hi_i       (div_hi_i),
        .lo_i       (div_lo_i),
        .shift_o    (shift_sel)
    );

    clkdiv_phase_gen phase_i (
        .clk_i       (clk_i),
        .rst_i       (hard_rst_i),
        .shift_sel_i (shift_sel),
        .ph1_o       (sys_ph1_o),
        .ph2_o       (sys_ph2_o),
        .ph1_nxt_o   (ph1_nxt),
        .ph2_nxt_o   (ph2_nxt),
        .wrap_o      (sys_wrap)
    );

    clkdiv_bus_stage bus_i (
        .clk_i         (clk_i),
        .rst_i         (hard_rst_i),
        .bus_div_i     (bus_div_i),
        .sys_wrap_i    (sys_wrap),
        .sys_ph1_nxt_i (ph1_nxt),
        .sys_ph2_nxt_i (ph2_nxt),
        .sys_ph1_i     (sys_ph1_o),
        .sys_ph2_i     (sys_ph2_o),
        .bus_ph1_o     (bus_ph1_o),
        .bus_ph2_o     (bus_ph2_o)
    );

endmodule

// File: tb/clkdiv_pwr_top_tb_top.sv
`timescale 1ns/1ps
module clkdiv_pwr_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic [2:0] dhi = 3'd0;
    logic [2:0] dlo = 3'd0;
    logic       bdiv = 1'b0;
    logic       sp1, sp2, bp1, bp2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clkdiv_pwr_top dut_i (
        .clk_i      (clk),
        .hard_rst_i (rst),
        .pwr_mode_i (mode),
        .div_hi_i   (dhi),
        .div_lo_i   (dlo),
        .bus_div_i  (bdiv),
        .sys_ph1_o  (sp1),
        .sys_ph2_o  (sp2),
        .bus_ph1_o  (bp1),
        .bus_ph2_o  (bp2)
    );

    function automatic logic p1v(input bit bus);
        return bus ? bp1 : sp1;
    endfunction

    function automatic logic p2v(input bit bus);
        return bus ? bp2 : sp2;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // wait for a fresh rise of the first phase, stop at that negedge
    task automatic sync_rise(input bit bus);
        int n = 0;
        while (p1v(bus) && n < 2000) begin @(negedge clk); n++; end
        while (!p1v(bus) && n < 2000) begin @(negedge clk); n++; end
    endtask

    // measure one full period starting at a rise of the first phase
    task automatic measure(input bit bus, input int exp_per, input int exp_off,
                           input string req);
        int per = 0;
        int h = 0;
        int off = -1;
        int w2 = 0;
        int bad = 0;
        logic prev;
        sync_rise(bus);
        do begin
            if (p1v(bus)) h++;
            if (p2v(bus)) begin
                if (off < 0) off = per;
                w2++;
            end
            if (p1v(bus) && p2v(bus)) bad++;
            if (bus && bp1 && !sp1) bad++;
            if (bus && bp2 && !sp2) bad++;
            prev = p1v(bus);
            @(negedge clk);
            per++;
        end while (!(p1v(bus) && !prev) && per < 1100);
        check(per == exp_per, req, "period", per, exp_per);
        check(h == 1, req, "ph1 high width", h, 1);
        check(off == exp_off, req, "ph2 offset", off, exp_off);
        check(w2 == 1, req, "ph2 high width", w2, 1);
        check(bad == 0, req, "overlap or misalignment", bad, 0);
    endtask

    // cycles from the current rise (ph1 high now) to the next rise
    task automatic count_period(output int per);
        logic prev;
        per = 0;
        do begin
            prev = sp1;
            @(negedge clk);
            per++;
        end while (!(sp1 && !prev) && per < 1100);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check({sp1, sp2, bp1, bp2} == 4'b0000, "R1", "outputs in reset",
              int'({sp1, sp2, bp1, bp2}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sp1 == 1'b1, "R1", "ph1 after release", int'(sp1), 1);
        measure(1'b0, 2, 1, "R1");
        measure(1'b1, 2, 1, "R1");
    endtask

    task automatic t_high();
        mode = 2'b00;
        foreach (dhi_list[i]) begin
            dhi = dhi_list[i];
            measure(1'b0, 2 << dhi_list[i], 1 << dhi_list[i], "R3");
        end
        dhi = 3'd2;
        measure(1'b0, 8, 4, "R2");
    endtask

    task automatic t_low();
        mode = 2'b10;
        for (int k = 0; k < 8; k++) begin
            int e;
            e = (k + 1 > 7) ? 7 : k + 1;
            dlo = 3'(k);
            measure(1'b0, 2 << e, 1 << e, "R4");
        end
    endtask

    task automatic t_doze();
        mode = 2'b01;
        dhi = 3'd1;
        dlo = 3'd5;
        measure(1'b0, 4, 2, "R5");
        mode = 2'b11;
        dhi = 3'd6;
        dlo = 3'd0;
        measure(1'b0, 4, 2, "R5");
        mode = 2'b10;
        measure(1'b0, 4, 2, "R5");
    endtask

    task automatic t_bus();
        mode = 2'b00;
        bdiv = 1'b1;
        for (int k = 0; k < 3; k++) begin
            dhi = 3'(k);
            measure(1'b1, 4 << k, 3 << k, "R8");
            measure(1'b0, 2 << k, 1 << k, "R8");
        end
        bdiv = 1'b0;
        dhi = 3'd2;
        measure(1'b1, 8, 4, "R7");
    endtask

    task automatic t_boundary();
        int per;
        mode = 2'b00;
        bdiv = 1'b0;
        dhi = 3'd2;
        sync_rise(1'b0);
        sync_rise(1'b0);
        repeat (2) @(negedge clk);
        dhi = 3'd0;
        per = 2;
        begin
            int rest;
            count_period(rest);
            per = per + rest;
        end
        check(per == 8, "R6", "period after mid change", per, 8);
        count_period(per);
        check(per == 2, "R6", "period after boundary", per, 2);
        // mode switch during a divide-by-one period
        dlo = 3'd1;
        mode = 2'b10;
        count_period(per);
        check(per == 2, "R6", "period after mode switch", per, 2);
        count_period(per);
        check(per == 8, "R6", "low mode period", per, 8);
    endtask

    logic [2:0] dhi_list [4] = '{3'd0, 3'd1, 3'd2, 3'd7};

    initial begin
        t_reset();
        t_high();
        t_low();
        t_doze();
        t_bus();
        t_boundary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule